// File: doc/BRIEF.md
# Wide Value Byte-Access Register Window

This block lets a host with a narrow data bus read and write a value that is several bytes wide and lives in neighbouring logic. The wide value is held in a bank of byte-sized holding registers that occupy consecutive host addresses starting at a base address. The holding bank always drives the outgoing wide bus. A host write lands in the byte it addresses. A write to the most significant byte also produces a one-cycle write strobe, so the neighbour knows the whole assembled value is ready.

A host read of the least significant byte takes an atomic snapshot. A small three-state machine stalls the host handshake and raises a one-cycle read strobe toward the neighbour. During that cycle every holding byte loads from the incoming wide bus. The read then completes with the freshly captured low byte. The host reads the remaining bytes afterwards, so all the bytes it sees belong to the same instant. The host side uses a request/acknowledge handshake: the host holds its request until it sees a one-cycle acknowledge, and then drops it.

Top module: `wide_snap_window`

## Requirements
- R1: After synchronous reset, ack, rd_stb, wr_stb, host_rdata and ext_out are all zero.
- R2: Byte i sits at address BASE_ADDR+i and maps to bits [(i+1)*DATA_W-1 : i*DATA_W] of ext_out and ext_in (byte 0 is least significant).
- R3: A host write to a mapped byte updates that byte of ext_out on the first clock edge. The acknowledge is seen after that edge, and no other byte changes.
- R4: A host read of byte 0 raises rd_stb for exactly one cycle, beginning after the first edge. All bytes load from the ext_in value present during that strobe cycle. The acknowledge follows after the third edge, and host_rdata carries the newly captured byte 0. Changes on ext_in at any other time have no effect on ext_out.
- R5: A read request to byte 0 that is held past its acknowledge produces no second rd_stb until the request has dropped.
- R6: A write to the highest byte gives a single-cycle wr_stb after the first edge. Writes to other bytes give no wr_stb.
- R7: A host read of a mapped byte other than byte 0 is acknowledged after the first edge with that byte's held value, and gives no rd_stb.
- R8: A request to an address outside the window is acknowledged after the first edge. A read of such an address returns zero, and a write to it changes no byte.
- R9: Every acknowledge lasts exactly one cycle, and ack stays low in the cycle after rd_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request, held until ack is seen |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_ack | output | 1 | One-cycle acknowledge |
| host_rdata | output | DATA_W | Read data, valid while host_ack is high |
| ext_in | input | NUM_BYTES*DATA_W | Wide value offered by the neighbour |
| ext_out | output | NUM_BYTES*DATA_W | Assembled holding bytes |
| rd_stb | output | 1 | Snapshot strobe toward the neighbour |
| wr_stb | output | 1 | Commit strobe after a write of the highest byte |

## Verification
A seeded random mix of reads and writes covers every mapped byte and an unmapped address, with ext_in changing between operations. This shows that only byte-0 reads sample the incoming bus and that writes touch only their own byte. Directed cases cover four things. A byte-0 read with ext_in differing from the held value tells a fresh capture apart from a stale return. A held byte-0 request tells a single strobe apart from a repeated one. Writes to the top byte and to a lower byte tell the commit strobe apart from spurious strobes. Latency is measured on every operation, which separates the stalled snapshot read from the single-cycle accesses.

// File: rtl/wide_snap_pkg.sv
package wide_snap_pkg;
  typedef enum logic [1:0] {
    SNAP_IDLE = 2'd0,
    SNAP_REQ  = 2'd1,
    SNAP_DONE = 2'd2
  } snap_state_e;
endpackage

// File: rtl/wide_snap_decode.sv
module wide_snap_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter int BASE_ADDR = 'h40
) (
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic                 host_ack,
  input  logic [ADDR_W-1:0]    host_addr,
  output logic [NUM_BYTES-1:0] rd_sel,
  output logic [NUM_BYTES-1:0] wr_sel,
  output logic                 hit
);
  localparam int SEL_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [ADDR_W-1:0] BASE_V = BASE_ADDR[ADDR_W-1:0];

  logic             base_match;
  logic [SEL_W-1:0] idx;

  assign base_match = (host_addr[ADDR_W-1:SEL_W] == BASE_V[ADDR_W-1:SEL_W]);
  assign idx        = host_addr[SEL_W-1:0];

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sel
    logic here;
    assign here      = base_match && (idx == SEL_W'(i));
    // reads stay selected while held; writes act once per request
    assign rd_sel[i] = here && host_req && !host_we;
    assign wr_sel[i] = here && host_req && host_we && !host_ack;
  end

  assign hit = |(rd_sel | wr_sel) || (base_match && host_req && host_we);
endmodule

// File: rtl/wide_snap_fsm.sv
module wide_snap_fsm
  import wide_snap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_sel0,
  output logic rd_stb,
  output logic wait_n
);
  snap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    wait_n  = 1'b1;
    case (state_q)
      SNAP_IDLE: if (rd_sel0) begin
        state_d = SNAP_REQ;
        wait_n  = 1'b0;
      end
      SNAP_REQ: begin
        state_d = SNAP_DONE;
        wait_n  = 1'b0;
      end
      SNAP_DONE: if (!rd_sel0) state_d = SNAP_IDLE;
      default:   state_d = SNAP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SNAP_IDLE;
    else     state_q <= state_d;
  end

  assign rd_stb = (state_q == SNAP_REQ);

  // R4: the host is stalled throughout the strobe cycle
  a_r4_stall_on_strobe: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> !wait_n);
  // R4: strobe lasts one cycle
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);
  // R5: a held request parked in done does not re-strobe
  a_r5_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (state_q == SNAP_DONE && rd_sel0) |=> !rd_stb);
endmodule

// File: rtl/wide_snap_hold.sv
module wide_snap_hold #(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic [NUM_BYTES*DATA_W-1:0]   ext_in,
  input  logic [NUM_BYTES-1:0]          wr_sel,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NUM_BYTES*DATA_W-1:0]   hold_flat
);
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    logic [DATA_W-1:0] q, d;
    always_comb begin
      if (load)           d = ext_in[i*DATA_W +: DATA_W];
      else if (wr_sel[i]) d = wdata;
      else                d = q;
    end
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
    assign hold_flat[i*DATA_W +: DATA_W] = q;

    // R4: a snapshot captures this byte's slice of the incoming bus
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
      load |=> (q == $past(ext_in[i*DATA_W +: DATA_W])));
  end
endmodule

// File: rtl/wide_snap_window.sv
module wide_snap_window #(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h40
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        host_req,
  input  logic                        host_we,
  input  logic [ADDR_W-1:0]           host_addr,
  input  logic [DATA_W-1:0]           host_wdata,
  output logic                        host_ack,
  output logic [DATA_W-1:0]           host_rdata,
  input  logic [NUM_BYTES*DATA_W-1:0] ext_in,
  output logic [NUM_BYTES*DATA_W-1:0] ext_out,
  output logic                        rd_stb,
  output logic                        wr_stb
);
  localparam int VAL_W = NUM_BYTES * DATA_W;

  logic [NUM_BYTES-1:0] rd_sel, wr_sel;
  logic                 hit, wait_n, ack_d;
  logic [VAL_W-1:0]     hold_flat;
  logic [DATA_W-1:0]    rd_mux;

  wide_snap_decode #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BASE_ADDR(BASE_ADDR)) u_dec (
    .host_req(host_req), .host_we(host_we), .host_ack(host_ack), .host_addr(host_addr),
    .rd_sel(rd_sel), .wr_sel(wr_sel), .hit(hit));

  wide_snap_fsm u_fsm (
    .clk(clk), .rst(rst), .rd_sel0(rd_sel[0]), .rd_stb(rd_stb), .wait_n(wait_n));

  wide_snap_hold #(.DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_hold (
    .clk(clk), .rst(rst), .load(rd_stb), .ext_in(ext_in), .wr_sel(wr_sel),
    .wdata(host_wdata), .hold_flat(hold_flat));

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_BYTES; i++)
      if (rd_sel[i]) rd_mux = hold_flat[i*DATA_W +: DATA_W];
  end

  assign ack_d = host_req && wait_n && !host_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
      wr_stb     <= 1'b0;
    end else begin
      host_ack <= ack_d;
      if (ack_d && !host_we) host_rdata <= rd_mux;
      wr_stb   <= wr_sel[NUM_BYTES-1];
    end
  end

  assign ext_out = hold_flat;

  // R9: acknowledge is a single-cycle pulse
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);
  // R9: no acknowledge right after a snapshot strobe
  a_r9_no_ack_after_stb: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !host_ack);
  // R6: commit strobe is a single pulse and only follows a write
  a_r6_wr_stb_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  a_r6_wr_stb_cause: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(host_req && host_we));
  // R8: an unmapped request never disturbs the holding bank
  a_r8_miss_stable: assert property (@(posedge clk) disable iff (rst)
    (host_req && !hit && !rd_stb) |=> $stable(ext_out));
endmodule

// File: tb/sim_wide_snap_window.sv
`timescale 1ns/1ps
module sim_wide_snap_window;
  localparam int DW = 8, NB = 4, AW = 8, BASE = 'h40;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB*DW-1:0] ext_in = '0;
  logic ack, rd_stb, wr_stb;
  logic [DW-1:0] rdata;
  logic [NB*DW-1:0] ext_out;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mdl [NB];

  always #2.5 clk = ~clk;

  wide_snap_window #(.DATA_W(DW), .NUM_BYTES(NB), .ADDR_W(AW), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst(rst), .host_req(req), .host_we(we), .host_addr(addr),
    .host_wdata(wdata), .host_ack(ack), .host_rdata(rdata), .ext_in(ext_in),
    .ext_out(ext_out), .rd_stb(rd_stb), .wr_stb(wr_stb));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NB*DW-1:0] model_val();
    logic [NB*DW-1:0] v;
    for (int i = 0; i < NB; i++) v[i*DW +: DW] = mdl[i];
    return v;
  endfunction

  task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output int lat, output logic [DW-1:0] rd, output int nrd, output int nwr);
    req = 1'b1; we = wr; addr = a; wdata = d;
    lat = 0; nrd = 0; nwr = 0;
    do begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (rd_stb) nrd++;
      if (wr_stb) nwr++;
    end while (!ack && lat < 20);
    rd = rdata;
    req = 1'b0; we = 1'b0;
    @(posedge clk); @(negedge clk);
    if (rd_stb) nrd++;
    if (wr_stb) nwr++;
  endtask

  // full operation with expected values derived from the requirement list
  task automatic op_checked(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat, nrd, nwr, idx;
    logic [DW-1:0] rd, exp_rd;
    logic mapped;
    mapped = (a >= AW'(BASE)) && (a < AW'(BASE + NB));
    idx = mapped ? int'(a - AW'(BASE)) : -1;
    exp_rd = '0;
    if (!wr && idx == 0) for (int i = 0; i < NB; i++) mdl[i] = ext_in[i*DW +: DW];
    if (wr && mapped) mdl[idx] = d;
    if (!wr && mapped) exp_rd = mdl[idx];
    do_op(wr, a, d, lat, rd, nrd, nwr);
    if (!wr && idx == 0) begin
      chk("R4 snapshot latency", 64'(lat), 64'd3);
      chk("R4 snapshot strobe count", 64'(nrd), 64'd1);
      chk("R4 fresh byte0 data", 64'(rd), 64'(exp_rd));
    end else begin
      chk(mapped ? "R3/R7 single-cycle latency" : "R8 miss latency", 64'(lat), 64'd1);
      chk("R7 no snapshot strobe", 64'(nrd), 64'd0);
    end
    if (!wr) chk(mapped ? "R7 read data" : "R8 miss reads zero", 64'(rd), 64'(exp_rd));
    chk("R6 commit strobe count", 64'(nwr), (wr && idx == NB-1) ? 64'd1 : 64'd0);
    chk("R2 R3 ext_out contents", 64'(ext_out), 64'(model_val()));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int lat, nrd, nwr;
    logic [DW-1:0] rd;
    void'($urandom(32'd2718));
    for (int i = 0; i < NB; i++) mdl[i] = '0;
    ext_in = 32'hA5C3_1E77;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ack reset", 64'(ack), 0);
    chk("R1 rd_stb reset", 64'(rd_stb), 0);
    chk("R1 wr_stb reset", 64'(wr_stb), 0);
    chk("R1 rdata reset", 64'(rdata), 0);
    chk("R1 ext_out reset", 64'(ext_out), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 byte placement: write each byte distinctly
    op_checked(1'b1, AW'(BASE + 0), 8'h11);
    op_checked(1'b1, AW'(BASE + 1), 8'h22);
    op_checked(1'b1, AW'(BASE + 2), 8'h33);
    chk("R6 no strobe before top byte", 64'(wr_stb), 0);
    op_checked(1'b1, AW'(BASE + 3), 8'h44);
    chk("R2 word layout", 64'(ext_out), 64'h4433_2211);

    // R4 incoming bus ignored without a byte-0 read
    ext_in = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    chk("R4 ext_in ignored", 64'(ext_out), 64'h4433_2211);
    op_checked(1'b0, AW'(BASE + 2), 8'h00);
    // snapshot differing from held value
    op_checked(1'b0, AW'(BASE + 0), 8'h00);
    chk("R4 whole word captured", 64'(ext_out), 64'hDEAD_BEEF);

    // R8 unmapped accesses
    op_checked(1'b1, AW'(8'h10), 8'h99);
    op_checked(1'b0, AW'(8'h10), 8'h00);

    // R5 held byte-0 read: strobe only once while request stays high
    ext_in = 32'h0102_0304;
    req = 1'b1; we = 1'b0; addr = AW'(BASE);
    nrd = 0; nwr = 0;
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); @(negedge clk);
      if (rd_stb) nrd++;
      if (ack) nwr++;
    end
    req = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R5 held read strobes once", 64'(nrd), 64'd1);
    chk("R9 acks are pulses under held request", 64'(nwr >= 2 && nwr <= 3), 64'd1);
    for (int i = 0; i < NB; i++) mdl[i] = ext_in[i*DW +: DW];
    chk("R5 captured value", 64'(ext_out), 64'h0102_0304);
    @(negedge clk);

    // random mix
    for (int k = 0; k < 80; k++) begin
      int sel;
      logic [AW-1:0] a;
      ext_in = $urandom;
      sel = int'($urandom_range(0, NB));
      a = (sel == NB) ? AW'(8'h7E) : AW'(BASE + sel);
      op_checked(1'($urandom_range(0, 1)), a, 8'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule